// File: doc/BRIEF.md
# String Load Register-Fill Sequencer

This block carries out one load-string-immediate operation. It receives a decoded 32-bit instruction word, a base address and a one-cycle start strobe. When the word holds the string-load encoding, the block reads a byte-granular count of bytes, one byte at a time, from consecutive addresses. It packs the bytes into 32-bit words, most-significant byte first, and writes each finished word to a 32-entry register-file write port. The write index starts at the destination register named in the instruction and steps upward, wrapping from 31 to 0.

The memory side has two channels. The request channel is valid/ready: the block raises `rd_req_valid` with an address and keeps both stable until it sees `rd_req_ready`. The response channel is a plain valid strobe, and the block always accepts it because only one read is ever in flight. The register-file port has no back-pressure: each write is a one-cycle enable carrying the index and the value. A one-cycle `done` pulse closes every operation. This includes an instruction whose opcode does not match, which performs no reads and no writes.

Top module: `strfill_seq`

## Requirements
- R1: The operation runs only when instruction bits [31:26] equal 31 and bits [10:1] equal 597, so the base encoding is 0x7c0004aa. Bit [0] has no effect.
- R2: A start with a non-matching instruction raises `done` in the cycle after the start edge. It makes no read requests and no register writes.
- R3: The destination index is taken from bits [25:21] and the byte count from bits [15:11]. A count field of 0 transfers 32 bytes. Any other value N transfers exactly N bytes, and the block issues exactly that many read requests.
- R4: When the base-register field in bits [20:16] is zero, the first read address is 0 and `base_addr` is ignored. Otherwise the first read address is `base_addr`.
- R5: Each further read address is the previous one plus 1, wrapping modulo 2^32.
- R6: In each written word, the first byte of its group is in bits [31:24], the second in [23:16], the third in [15:8] and the fourth in [7:0].
- R7: When the count is not a multiple of 4, the last written word carries zeros in its unused low-order bytes.
- R8: Successive register writes use indices that rise by one modulo 32, starting at the destination index, so 31 is followed by 0. The number of writes is the count divided by 4, rounded up.
- R9: At most one read is outstanding. While `rd_req_valid` is high and `rd_req_ready` is low, the request and its address stay unchanged.
- R10: Each register write is a one-cycle `rf_we` pulse. It appears in the cycle after the response that completes its word.
- R11: `done` is a one-cycle pulse in the cycle after the last register write, and it never coincides with a write.
- R12: Out of reset the block is idle, with `busy`, `done`, `rf_we` and `rd_req_valid` low. A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| instr | input | 32 | Instruction word |
| base_addr | input | 32 | Base register value used when the base field is nonzero |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Byte read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the request |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 8 | Returned byte |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 5 | Register-file write index |
| rf_data | output | 32 | Register-file write value |

## Verification
The bound checker watches every cycle for the protocol-level behaviour. It checks that a stalled request holds its address, that no second read starts before the first response, that request addresses within an operation step by one, and that write indices step by one modulo 32. It also checks that writes and `done` are single-cycle, never overlap, and happen only while busy. The byte content of each word, its zero padding, the count-of-zero rule, the address source for a zero base field, the exact cycles of writes and `done`, and the dropping of a mid-operation start depend on the instruction given. Only the bench's directed scenarios show these, by comparing against values computed from the instruction and a known memory pattern.

// File: rtl/strfill_pkg.sv
package strfill_pkg;
  localparam logic [5:0] OP_PRIMARY = 6'd31;
  localparam logic [9:0] OP_EXT     = 10'd597;
  localparam int FIELD_W = 5;
  localparam int CNT_W   = FIELD_W + 1;
  localparam logic [CNT_W-1:0] ZERO_MEANS = CNT_W'(32);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_WR,
    ST_DONE
  } seq_state_t;

  function automatic logic [CNT_W-1:0] field_to_count(input logic [FIELD_W-1:0] f);
    return (f == '0) ? ZERO_MEANS : {1'b0, f};
  endfunction
endpackage

// File: rtl/strfill_decode.sv
module strfill_decode
  import strfill_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [31:0]        instr,
  input  logic [ADDR_W-1:0]  base_addr,
  output logic               match,
  output logic [FIELD_W-1:0] dest,
  output logic [CNT_W-1:0]   count,
  output logic [ADDR_W-1:0]  ea_start
);
  logic [FIELD_W-1:0] base_fld;
  logic               rc_unused;

  assign match     = (instr[31:26] == OP_PRIMARY) && (instr[10:1] == OP_EXT);
  assign dest      = instr[25:21];
  assign base_fld  = instr[20:16];
  assign count     = field_to_count(instr[15:11]);
  assign ea_start  = (base_fld == '0) ? '0 : base_addr;
  assign rc_unused = instr[0];
endmodule

// File: rtl/strfill_cursor.sv
module strfill_cursor
  import strfill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ea0,
  input  logic [CNT_W-1:0]  cnt0,
  input  logic [IDX_W-1:0]  idx0,
  input  logic              addr_step,
  input  logic              byte_take,
  input  logic              word_step,
  output logic [ADDR_W-1:0] ea,
  output logic [LANE_W-1:0] lane,
  output logic [IDX_W-1:0]  idx,
  output logic              group_end,
  output logic              all_taken
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea     <= '0;
      remain <= '0;
      lane   <= '0;
      idx    <= '0;
    end else if (load) begin
      ea     <= ea0;
      remain <= cnt0;
      lane   <= '0;
      idx    <= idx0;
    end else begin
      if (addr_step) ea <= ea + 1'b1;
      if (byte_take) begin
        remain <= remain - 1'b1;
        lane   <= lane + 1'b1;
      end
      if (word_step) begin
        lane <= '0;
        idx  <= idx + 1'b1;
      end
    end
  end

  assign group_end = (lane == LANE_W'(LANES - 1)) || (remain == CNT_W'(1));
  assign all_taken = (remain == '0);
endmodule

// File: rtl/strfill_pack.sv
module strfill_pack #(
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        din,
  output logic [WORD_W-1:0] word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        q <= '0;
      else if (wr && lane == LANE_W'(g))
        q <= din;
    end
    assign word[WORD_W-1-8*g -: 8] = q;
  end
endmodule

// File: rtl/strfill_seq.sv
module strfill_seq
  import strfill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int REGS   = 32,
  localparam int IDX_W  = $clog2(REGS),
  localparam int LANES  = WORD_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [WORD_W-1:0] rf_data
);
  seq_state_t state_q, state_d;

  logic               match;
  logic [FIELD_W-1:0] dest;
  logic [CNT_W-1:0]   count;
  logic [ADDR_W-1:0]  ea_start, ea;
  logic [LANE_W-1:0]  lane;
  logic [IDX_W-1:0]   idx;
  logic               group_end, all_taken;
  logic               load, addr_step, byte_take, word_step;

  strfill_decode #(.ADDR_W(ADDR_W)) u_decode (
    .instr    (instr),
    .base_addr(base_addr),
    .match    (match),
    .dest     (dest),
    .count    (count),
    .ea_start (ea_start)
  );

  assign load      = (state_q == ST_IDLE) && start && match;
  assign addr_step = (state_q == ST_REQ) && rd_req_ready;
  assign byte_take = (state_q == ST_RSP) && rd_rsp_valid;
  assign word_step = (state_q == ST_WR);

  strfill_cursor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANES(LANES)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ea0      (ea_start),
    .cnt0     (count),
    .idx0     (IDX_W'(dest)),
    .addr_step(addr_step),
    .byte_take(byte_take),
    .word_step(word_step),
    .ea       (ea),
    .lane     (lane),
    .idx      (idx),
    .group_end(group_end),
    .all_taken(all_taken)
  );

  strfill_pack #(.WORD_W(WORD_W)) u_pack (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (load || word_step),
    .wr   (byte_take),
    .lane (lane),
    .din  (rd_rsp_data),
    .word (rf_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = match ? ST_REQ : ST_DONE;
      ST_REQ:  if (rd_req_ready) state_d = ST_RSP;
      ST_RSP:  if (rd_rsp_valid) state_d = group_end ? ST_WR : ST_REQ;
      ST_WR:   state_d = all_taken ? ST_DONE : ST_REQ;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_req_addr  = ea;
  assign rf_we        = word_step;
  assign rf_idx       = idx;
endmodule

// File: rtl/strfill_chk.sv
module strfill_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_idx
);
  logic              inflight_q;
  logic              have_addr_q, have_idx_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [IDX_W-1:0]  last_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight_q  <= 1'b0;
      have_addr_q <= 1'b0;
      have_idx_q  <= 1'b0;
      last_addr_q <= '0;
      last_idx_q  <= '0;
    end else begin
      if (rd_req_valid && rd_req_ready) inflight_q <= 1'b1;
      else if (rd_rsp_valid)            inflight_q <= 1'b0;
      if (done) begin
        have_addr_q <= 1'b0;
        have_idx_q  <= 1'b0;
      end else begin
        if (rd_req_valid && rd_req_ready) begin
          have_addr_q <= 1'b1;
          last_addr_q <= rd_req_addr;
        end
        if (rf_we) begin
          have_idx_q <= 1'b1;
          last_idx_q <= rf_idx;
        end
      end
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  // R9
  single_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> !rd_req_valid);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && have_addr_q |-> rd_req_addr == last_addr_q + 1'b1);
  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && have_idx_q |-> rf_idx == last_idx_q + 1'b1);
  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  // R10
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && rf_we));
endmodule

bind strfill_seq strfill_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid),
  .rf_we       (rf_we),
  .rf_idx      (rf_idx)
);

// File: tb/test_strfill_seq.sv
`timescale 1ns/1ps
module test_strfill_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_addr = '0;
  logic        busy, done, rd_req_valid, rf_we;
  logic        rd_req_ready = 1'b1;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = '0;
  logic [4:0]  rf_idx;
  logic [31:0] rf_data;

  always #2.5 clk = ~clk;

  strfill_seq i_strfill_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base_addr(base_addr),
    .busy(busy), .done(done), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[31:28]} ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] p, input logic [4:0] rt,
                                     input logic [4:0] ra, input logic [4:0] nb,
                                     input logic [9:0] xo, input logic rc);
    return {p, rt, ra, nb, xo, rc};
  endfunction

  // memory model
  bit   stall = 0;
  int   rsp_lat = 0;
  logic pend = 0;
  logic [31:0] paddr = '0;
  int   pwait = 0;
  always @(posedge clk) begin
    rd_rsp_valid <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0;
      rd_req_ready <= 1'b1;
    end else begin
      if (pend) begin
        if (pwait == 0) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= mem_byte(paddr);
          pend <= 1'b0;
        end else pwait <= pwait - 1;
      end else if (rd_req_valid && rd_req_ready) begin
        pend  <= 1'b1;
        paddr <= rd_req_addr;
        pwait <= rsp_lat;
      end
      rd_req_ready <= stall ? ~rd_req_ready : 1'b1;
    end
  end

  // monitor
  logic [4:0]  w_idx [64];
  logic [31:0] w_dat [64];
  int          w_cyc [64];
  logic [31:0] r_addr[64];
  int          s_cyc [64];
  int nw, nr, ns, n_done, done_cyc, hold_err;
  logic hold_prev;
  logic [31:0] hold_addr;

  task automatic clear_log();
    nw = 0; nr = 0; ns = 0; n_done = 0; done_cyc = -1; hold_err = 0; hold_prev = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we && nw < 64) begin
        w_idx[nw] = rf_idx; w_dat[nw] = rf_data; w_cyc[nw] = cyc; nw++;
      end
      if (rd_req_valid && rd_req_ready && nr < 64) begin
        r_addr[nr] = rd_req_addr; nr++;
      end
      if (rd_rsp_valid && ns < 64) begin
        s_cyc[ns] = cyc; ns++;
      end
      if (done) begin
        n_done++; done_cyc = cyc;
      end
      if (hold_prev && !(rd_req_valid && rd_req_addr == hold_addr)) hold_err++;
      hold_prev = rd_req_valid && !rd_req_ready;
      hold_addr = rd_req_addr;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  int start_cyc;

  task automatic launch(input logic [31:0] ins, input logic [31:0] base);
    @(negedge clk);
    clear_log();
    instr = ins; base_addr = base; start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (n_done == 0 && t < 4000) begin
      @(negedge clk); t++;
    end
    if (n_done == 0) begin
      n_chk++; n_err++;
      $display("FAIL %s timeout: actual no done expected done", req);
    end
  endtask

  // compare one finished operation against values computed from the instruction
  task automatic verify_op(input logic [31:0] ins, input logic [31:0] base, input string req);
    int n, nwords, last;
    logic [31:0] ea0, exp_w;
    n      = (ins[15:11] == 0) ? 32 : int'(ins[15:11]);
    ea0    = (ins[20:16] == 0) ? 32'h0 : base;
    nwords = (n + 3) / 4;
    chk({req, " R3"}, "read count", nr, n);
    chk({req, " R4"}, "first address", r_addr[0], ea0);
    for (int i = 1; i < n && i < 64; i++)
      chk({req, " R5"}, "address step", r_addr[i], ea0 + i);
    chk({req, " R8"}, "write count", nw, nwords);
    for (int k = 0; k < nwords && k < nw; k++) begin
      exp_w = '0;
      for (int j = 0; j < 4; j++)
        if (4*k + j < n) exp_w[31-8*j -: 8] = mem_byte(ea0 + 4*k + j);
      chk({req, " R8"}, "write index", w_idx[k], 5'(ins[25:21] + k));
      chk({req, " R6 R7"}, "write data", w_dat[k], exp_w);
    end
    last = (n < 4) ? n - 1 : 3;
    if (nw > 0 && ns > last)
      chk({req, " R10"}, "first write cycle", w_cyc[0], s_cyc[last] + 1);
    if (nw > 0)
      chk({req, " R11"}, "done cycle", done_cyc, w_cyc[nw-1] + 1);
    chk({req, " R11"}, "done count", n_done, 1);
    chk({req, " R9"}, "request hold", hold_err, 0);
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [31:0] base, input string req);
    launch(ins, base);
    wait_done(req);
    verify_op(ins, base, req);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12", "busy after reset", busy, 0);
    chk("R12", "done after reset", done, 0);
    chk("R12", "rf_we after reset", rf_we, 0);
    chk("R12", "rd_req_valid after reset", rd_req_valid, 0);
  endtask

  task automatic t_basic();
    run_op(mk(6'd31, 5'd3, 5'd4, 5'd8, 10'd597, 1'b0), 32'h0000_1000, "R1 basic");
  endtask

  task automatic t_rc_set();
    run_op(mk(6'd31, 5'd10, 5'd1, 5'd4, 10'd597, 1'b1), 32'h00AB_CD00, "R1 rc bit");
  endtask

  task automatic t_full_wrap();
    run_op(mk(6'd31, 5'd29, 5'd2, 5'd0, 10'd597, 1'b0), 32'h1234_5670, "R3 R8 count32 wrap");
  endtask

  task automatic t_ra_zero();
    run_op(mk(6'd31, 5'd0, 5'd0, 5'd7, 10'd597, 1'b0), 32'hDEAD_BEEF, "R4 base zero");
  endtask

  task automatic t_addr_wrap();
    run_op(mk(6'd31, 5'd31, 5'd9, 5'd6, 10'd597, 1'b0), 32'hFFFF_FFFE, "R5 addr wrap");
  endtask

  task automatic t_single();
    run_op(mk(6'd31, 5'd17, 5'd3, 5'd1, 10'd597, 1'b0), 32'h0000_0042, "R7 single byte");
  endtask

  task automatic t_stall();
    stall = 1; rsp_lat = 3;
    run_op(mk(6'd31, 5'd5, 5'd6, 5'd11, 10'd597, 1'b0), 32'h8000_0101, "R9 back-pressure");
    stall = 0; rsp_lat = 0;
  endtask

  task automatic t_nomatch(input logic [31:0] ins, input string what);
    launch(ins, 32'h0000_4000);
    wait_done("R2");
    chk("R2", {what, " done cycle"}, done_cyc, start_cyc + 1);
    chk("R2", {what, " reads"}, nr, 0);
    chk("R2", {what, " writes"}, nw, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_busy_start();
    logic [31:0] a;
    a = mk(6'd31, 5'd7, 5'd8, 5'd12, 10'd597, 1'b0);
    launch(a, 32'h0000_0200);
    repeat (4) @(negedge clk);
    instr = mk(6'd31, 5'd20, 5'd0, 5'd3, 10'd597, 1'b0);
    base_addr = 32'h0000_9000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R12");
    verify_op(a, 32'h0000_0200, "R12 busy start");
    repeat (20) @(negedge clk);
    chk("R12", "no extra done", n_done, 1);
    chk("R12", "no extra writes", nw, 3);
    chk("R12", "idle after", busy, 0);
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_rc_set();
    t_full_wrap();
    t_ra_zero();
    t_addr_wrap();
    t_single();
    t_stall();
    t_nomatch(mk(6'd30, 5'd3, 5'd4, 5'd8, 10'd597, 1'b0), "primary");
    t_nomatch(mk(6'd31, 5'd3, 5'd4, 5'd8, 10'd533, 1'b0), "extended");
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule